// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of up to 32 pins, controlled through a simple 32-bit register bus. Software sets an output data word and a per-pin direction word, and the block drives them on `pin_out` and `pin_oe`. The external pin levels pass through a two-flop synchroniser. The synchronised value can be read back as the pad status word.

Each pin has its own interrupt condition. Software picks one of four conditions with a 2-bit code: low level, high level, rising edge or falling edge. A separate both-edge select bit makes the pin react to every transition, whatever its code. A detected condition sets a sticky status bit. Software clears that bit by writing a 1 to it. Status bits that are enabled in the mask raise one of two request lines, chosen by which half of the port the pin sits in. A third line is the OR of the two.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, every register reads as zero. Byte offsets 0x20 to 0x3C hold no register and always read zero.
- R2: The data word at offset 0x00 appears on `pin_out`. The direction word at offset 0x04 appears on `pin_oe`, where bit = 1 makes that pin an output. Both words read back the value last written.
- R3: Offset 0x08 returns `pin_in` after a two-flop synchroniser. A change made between clock edges is visible after the second rising edge. Writes to 0x08 have no effect.
- R4: Pin i below 16 takes its code from bits [2i+1:2i] of offset 0x0C. Pin i from 16 up takes its code from bits [2(i-16)+1:2(i-16)] of offset 0x10. The codes are 00 = low level, 01 = high level, 10 = rising edge and 11 = falling edge. An edge on a pin sets its status bit (offset 0x18) on the third rising edge after the pin changes. A level condition sets the status bit on every cycle that the condition holds.
- R5: When a pin's bit in offset 0x1C is 1, any transition of that pin sets its status bit and its 2-bit code is ignored. A steady pin then sets nothing, even if its code is a level code that the pin meets.
- R6: Writing a 1 to a bit of offset 0x18 clears that status bit. Writing a 0 leaves the bit unchanged.
- R7: If a detection and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R8: `irq_lo` is the OR over pins 0 to 15 of status AND mask (offset 0x14, bit = 1 enables the pin). `irq_hi` is the same OR over pins 16 to 31. `irq_any` is the OR of `irq_lo` and `irq_hi`.
- R9: While the mask word is zero, no request line is asserted. This holds even right after all-ones is written to the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 6 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | External pin levels |
| pin_out | output | 32 | Output data driven to the pins |
| pin_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Request for pins 0 to 15 |
| irq_hi | output | 1 | Request for pins 16 to 31 |
| irq_any | output | 1 | OR of both requests |

## Verification
The bench builds the block with its default values: 32 pins, a 6-bit byte address and two synchroniser stages. With these values both configuration halves are in use, so codes in the low register and the high register can each be tested, along with the split of requests between `irq_lo` and `irq_hi`. The sixth address bit gives a range of offsets with no register behind it, which the bench reads to test the zero returned there. The two-stage synchroniser sets the edge-to-status latency to three cycles, and the directed cases check that latency exactly.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef enum logic [2:0] {
    RI_DATA = 3'd0,
    RI_DIR  = 3'd1,
    RI_PAD  = 3'd2,
    RI_CFGL = 3'd3,
    RI_CFGH = 3'd4,
    RI_MASK = 3'd5,
    RI_STAT = 3'd6,
    RI_BOTH = 3'd7
  } reg_idx_e;

  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned MAP_TOP = IDX_LSB + IDX_W;

  // Decide whether one pin raises a detection this cycle.
  function automatic logic pin_event(trig_e code, logic both_sel,
                                     logic now_v, logic old_v);
    logic hit;
    if (both_sel) begin
      hit = now_v ^ old_v;
    end else begin
      case (code)
        TRIG_LOW:  hit = ~now_v;
        TRIG_HIGH: hit = now_v;
        TRIG_RISE: hit = now_v & ~old_v;
        default:   hit = ~now_v & old_v;
      endcase
    end
    return hit;
  endfunction

  // Extract the 2-bit trigger code of one slot of a configuration word.
  function automatic trig_e field_of(logic [31:0] cfg, int unsigned slot);
    return trig_e'(cfg[2*slot +: 2]);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_now,
  output logic [W-1:0] q_old
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_old <= '0;
    else        q_old <= stage[STAGES-1];
  end

  assign q_now = stage[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] cfg_lo,
  input  logic [NPINS-1:0] cfg_hi,
  input  logic [NPINS-1:0] both_sel,
  input  logic [NPINS-1:0] now_v,
  input  logic [NPINS-1:0] old_v,
  output logic [NPINS-1:0] evt_vec
);
  localparam int HALF = NPINS / 2;

  logic [31:0] cfg_lo_w;
  logic [31:0] cfg_hi_w;
  assign cfg_lo_w = 32'(cfg_lo);
  assign cfg_hi_w = 32'(cfg_hi);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int unsigned SLOT = i % HALF;
    trig_e code;
    if (i < HALF) begin : g_lo
      assign code = field_of(cfg_lo_w, SLOT);
    end else begin : g_hi
      assign code = field_of(cfg_hi_w, SLOT);
    end
    assign evt_vec[i] = pin_event(code, both_sel[i], now_v[i], old_v[i]);
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_v,
  input  logic [NPINS-1:0] evt_vec,
  output logic [NPINS-1:0] data_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] cfg_lo_q,
  output logic [NPINS-1:0] cfg_hi_q,
  output logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] stat_q,
  output logic [NPINS-1:0] both_q,
  output logic [NPINS-1:0] clr_vec
);
  reg_idx_e         idx;
  logic             in_map;
  logic             wr_en;
  logic [NPINS-1:0] wval;

  assign idx  = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
  assign wval = bus_wdata[NPINS-1:0];

  if (AW > MAP_TOP) begin : g_upper
    assign in_map = (bus_addr[AW-1:MAP_TOP] == '0);
  end else begin : g_flat
    assign in_map = 1'b1;
  end

  assign wr_en   = bus_sel & bus_wr & in_map;
  assign clr_vec = (wr_en && idx == RI_STAT) ? wval : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      both_q   <= '0;
    end else if (wr_en) begin
      case (idx)
        RI_DATA: data_q   <= wval;
        RI_DIR:  dir_q    <= wval;
        RI_CFGL: cfg_lo_q <= wval;
        RI_CFGH: cfg_hi_q <= wval;
        RI_MASK: mask_q   <= wval;
        RI_BOTH: both_q   <= wval;
        default: ;
      endcase
    end
  end

  // Sticky status: detections win over a clearing write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_vec) | evt_vec;
  end

  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      case (idx)
        RI_DATA: bus_rdata = DW'(data_q);
        RI_DIR:  bus_rdata = DW'(dir_q);
        RI_PAD:  bus_rdata = DW'(pad_v);
        RI_CFGL: bus_rdata = DW'(cfg_lo_q);
        RI_CFGH: bus_rdata = DW'(cfg_hi_q);
        RI_MASK: bus_rdata = DW'(mask_q);
        RI_STAT: bus_rdata = DW'(stat_q);
        default: bus_rdata = DW'(both_q);
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS       = 32,
  parameter int AW          = 6,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_lo,
  output logic             irq_hi,
  output logic             irq_any
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] sync_now, sync_old, evt_vec, clr_vec;
  logic [NPINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q, both_q;
  logic [NPINS-1:0] req_vec;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q_now (sync_now),
    .q_old (sync_old)
  );

  gpio_detect #(.NPINS(NPINS)) u_detect (
    .cfg_lo   (cfg_lo_q),
    .cfg_hi   (cfg_hi_q),
    .both_sel (both_q),
    .now_v    (sync_now),
    .old_v    (sync_old),
    .evt_vec  (evt_vec)
  );

  gpio_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_v     (sync_now),
    .evt_vec   (evt_vec),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .cfg_lo_q  (cfg_lo_q),
    .cfg_hi_q  (cfg_hi_q),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .both_q    (both_q),
    .clr_vec   (clr_vec)
  );

  assign req_vec = stat_q & mask_q;
  assign irq_lo  = |req_vec[HALF-1:0];
  assign irq_hi  = |req_vec[NPINS-1:HALF];
  assign irq_any = irq_lo | irq_hi;
  assign pin_out = data_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq_any,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] both_q,
  input logic [NPINS-1:0] evt_vec,
  input logic [NPINS-1:0] clr_vec,
  input logic [NPINS-1:0] sync_now,
  input logic [NPINS-1:0] sync_old
);
  p_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(4)) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

  p_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & both_q) == (both_q & (sync_now ^ sync_old))));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(clr_vec & ~evt_vec)) == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_vec)) == $past(stat_q & ~clr_vec)));

  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(evt_vec)) == $past(evt_vec)));

  p_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ((stat_q & mask_q) != '0));

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_any);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .irq_any   (irq_any),
  .mask_q    (mask_q),
  .stat_q    (stat_q),
  .both_q    (both_q),
  .evt_vec   (evt_vec),
  .clr_vec   (clr_vec),
  .sync_now  (sync_now),
  .sync_old  (sync_old)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_lo, irq_hi, irq_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
  );

  // Reference state built from the requirements.
  logic [31:0] m_data, m_dir, m_cfgl, m_cfgh, m_mask, m_stat, m_both;
  logic [31:0] m_s1, m_s2, m_old;

  function automatic bit m_fires(int p);
    logic [1:0] code;
    bit cur, prv;
    cur = m_s2[p];
    prv = m_old[p];
    if (p < 16) code = 2'((m_cfgl >> (2*p)) & 32'h3);
    else        code = 2'((m_cfgh >> (2*(p-16))) & 32'h3);
    if (m_both[p]) return cur != prv;
    if (code == 2'b00) return !cur;
    if (code == 2'b01) return cur;
    if (code == 2'b10) return cur && !prv;
    return !cur && prv;
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    if (a[5]) return 32'h0;
    case (a[4:2])
      3'd0: return m_data;
      3'd1: return m_dir;
      3'd2: return m_s2;
      3'd3: return m_cfgl;
      3'd4: return m_cfgh;
      3'd5: return m_mask;
      3'd6: return m_stat;
      default: return m_both;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] nstat;
    if (!rst_n) begin
      m_data <= 0; m_dir <= 0; m_cfgl <= 0; m_cfgh <= 0;
      m_mask <= 0; m_stat <= 0; m_both <= 0;
      m_s1 <= 0; m_s2 <= 0; m_old <= 0;
    end else begin
      nstat = m_stat;
      if (bus_sel && bus_wr && !bus_addr[5]) begin
        case (bus_addr[4:2])
          3'd0: m_data <= bus_wdata;
          3'd1: m_dir  <= bus_wdata;
          3'd3: m_cfgl <= bus_wdata;
          3'd4: m_cfgh <= bus_wdata;
          3'd5: m_mask <= bus_wdata;
          3'd6: nstat  = nstat & ~bus_wdata;
          3'd7: m_both <= bus_wdata;
          default: ;
        endcase
      end
      for (int p = 0; p < 32; p++) if (m_fires(p)) nstat[p] = 1'b1;
      m_stat <= nstat;
      m_s1 <= pin_in;
      m_s2 <= m_s1;
      m_old <= m_s2;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Continuous comparison of outputs against the reference.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pin_out", pin_out, m_data);
      chk("R2 pin_oe", pin_oe, m_dir);
      chk("R8 irq_lo", 32'(irq_lo), 32'(|(m_stat[15:0] & m_mask[15:0])));
      chk("R8 irq_hi", 32'(irq_hi), 32'(|(m_stat[31:16] & m_mask[31:16])));
      chk("R8 irq_any", 32'(irq_any), 32'(|(m_stat & m_mask)));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Read and compare with both a directed value and the reference.
  task automatic rd(string tag, logic [5:0] a, logic [31:0] exp);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1;
    chk(tag, bus_rdata, exp);
    chk(tag, bus_rdata, m_read(a));
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7051));
    // R1: reset state, and offsets without a register
    cyc(2);
    for (int k = 0; k < 16; k++) begin
      bus_addr = 6'(k*4); #1;
      chk("R1 reset read", bus_rdata, 32'h0);
    end
    chk("R1 reset irq", 32'({irq_lo, irq_hi, irq_any}), 32'h0);
    rst_n = 1'b1;
    cyc(3);
    rd("R1 unused 0x20", 6'h20, 32'h0);
    rd("R1 unused 0x3C", 6'h3C, 32'h0);

    // R9: mask off and all status cleared leaves nothing pending
    wr(6'h14, 32'h0);
    wr(6'h18, 32'hFFFF_FFFF);
    chk("R9 irq_any", 32'(irq_any), 32'h0);
    chk("R9 irq_lo", 32'(irq_lo), 32'h0);
    chk("R9 irq_hi", 32'(irq_hi), 32'h0);

    // R2: data and direction
    wr(6'h00, 32'hA5A5_0F0F);
    wr(6'h04, 32'h3C3C_FF00);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    chk("R2 pin_oe", pin_oe, 32'h3C3C_FF00);
    rd("R2 data read", 6'h00, 32'hA5A5_0F0F);
    rd("R2 dir read", 6'h04, 32'h3C3C_FF00);

    // R3: synchronised pad status, two-edge latency, read-only
    pin_in = 32'h1234_8001;
    cyc(1);
    rd("R3 pad after one edge", 6'h08, 32'h0);
    cyc(1);
    rd("R3 pad after two edges", 6'h08, 32'h1234_8001);
    wr(6'h08, 32'hFFFF_FFFF);
    rd("R3 pad write ignored", 6'h08, 32'h1234_8001);

    // R4: edge codes in both halves, with latency
    pin_in = 32'h0;
    wr(6'h0C, 32'hAAAA_AAAA);
    wr(6'h10, 32'hAAAA_ABAA);   // pin 20 falling
    wr(6'h1C, 32'h0);
    cyc(4);
    wr(6'h18, 32'hFFFF_FFFF);
    rd("R4 cleared", 6'h18, 32'h0);
    pin_in = 32'h0010_0008;
    cyc(2);
    rd("R4 not yet", 6'h18, 32'h0);
    cyc(1);
    rd("R4 rising pin3", 6'h18, 32'h0000_0008);
    wr(6'h18, 32'hFFFF_FFFF);
    pin_in = 32'h0;
    cyc(3);
    rd("R4 falling pin20", 6'h18, 32'h0010_0000);
    // R4: high level on pin 9
    wr(6'h0C, 32'hAAA6_AAAA);
    wr(6'h18, 32'hFFFF_FFFF);
    rd("R4 high level idle", 6'h18, 32'h0);
    pin_in = 32'h0000_0200;
    cyc(3);
    rd("R4 high level", 6'h18, 32'h0000_0200);
    // R7: clear collides with an active level
    wr(6'h18, 32'h0000_0200);
    rd("R7 bit kept", 6'h18, 32'h0000_0200);
    pin_in = 32'h0;
    cyc(3);
    wr(6'h18, 32'hFFFF_FFFF);
    rd("R4 level gone", 6'h18, 32'h0);
    // R4: low level on pin 9
    wr(6'h0C, 32'hAAA2_AAAA);
    cyc(1);
    rd("R4 low level", 6'h18, 32'h0000_0200);

    // R5: both-edge select overrides a high-level code on pin 5
    wr(6'h0C, 32'hAAAA_A6AA);
    wr(6'h1C, 32'h0000_0020);
    wr(6'h18, 32'hFFFF_FFFF);
    pin_in = 32'h0000_0020;
    cyc(3);
    rd("R5 rise", 6'h18, 32'h0000_0020);
    wr(6'h18, 32'hFFFF_FFFF);
    cyc(3);
    rd("R5 code ignored", 6'h18, 32'h0);
    pin_in = 32'h0;
    cyc(3);
    rd("R5 fall", 6'h18, 32'h0000_0020);

    // R6: write-one-to-clear
    wr(6'h18, 32'h0);
    rd("R6 zero write", 6'h18, 32'h0000_0020);
    wr(6'h18, 32'hFFFF_FFDF);
    rd("R6 other bits", 6'h18, 32'h0000_0020);
    wr(6'h18, 32'h0000_0020);
    rd("R6 cleared", 6'h18, 32'h0);

    // R8: request split by half
    wr(6'h1C, 32'h0);
    wr(6'h14, 32'h0002_0002);
    pin_in = 32'h0000_0006;
    cyc(3);
    chk("R8 lo set", 32'({irq_lo, irq_hi, irq_any}), 32'b101);
    pin_in = 32'h0002_0006;
    cyc(3);
    chk("R8 both set", 32'({irq_lo, irq_hi, irq_any}), 32'b111);
    wr(6'h18, 32'h0000_0002);
    chk("R8 hi only", 32'({irq_lo, irq_hi, irq_any}), 32'b011);
    wr(6'h18, 32'hFFFF_FFFF);
    chk("R8 none", 32'({irq_lo, irq_hi, irq_any}), 32'b000);

    // Random phase against the reference
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      pin_in = pin_in ^ ($urandom & $urandom & $urandom);
      bus_addr = 6'($urandom_range(0, 15) * 4);
      bus_wdata = $urandom;
      bus_sel = ($urandom_range(0, 3) == 0);
      bus_wr = bus_sel;
      if (bus_sel && bus_addr == 6'h14 && $urandom_range(0, 3) == 0) bus_wdata = 32'h0;
      #1;
      chk("R4 random read", bus_rdata, m_read(bus_addr));
    end
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule